// File: doc/BRIEF.md
# Serial EEPROM Paged Word Writer

This block writes a run of 16-bit words into a serial EEPROM over a four-wire link. The link is an active-low chip select, a serial clock, data to the device and data from the device. A host starts a transfer by pulsing a start strobe with a starting word index and a word count. The block checks those arguments and then runs the transfer one burst at a time. Each burst polls the device status until it reports idle, sends a write-enable command, and then sends a write command with the byte address. After that it streams data words, which it pulls from the host over a valid/ready channel.

A burst ends after the last word of the run, or after a word whose following byte address starts a new device page. The link then rests with chip select high for a fixed settle time, and the next burst starts with a fresh status poll. The bit period comes from a prescaler on the system clock. The command width, address width, page size, device size, poll limit and settle time are all parameters.

The word channel follows these back-pressure rules. `wdata_ready_o` is high only while the block waits for the next word of the current burst. A word transfers on a clock edge where valid and ready are both high. While ready is high and valid is low, the link is frozen, with no serial clock edges. The host may raise valid at any time, and the data must be held until the transfer happens.

Top module: `spi_eeprom_page_writer`

## Requirements
- R1: A start is refused with a one-cycle `err_o` pulse, due exactly one clock after the start edge, when the word index is at or past DEV_WORDS, when the count is zero, or when the count is larger than DEV_WORDS minus the index. A refused start causes no chip-select or clock activity. A run that ends exactly at the last word is accepted.
- R2: Each burst opens by selecting the device and sending command 0x05, then clocking in 8 status bits. If status bit 0 (the last bit received) is 1, chip select is pulsed high and then low, and the poll repeats. Every other status bit is ignored.
- R3: After RETRY_MAX polls that all read busy, chip select goes high, `err_o` pulses once, no write-enable or write command is sent, and the block accepts new starts again.
- R4: Once the device reports idle, command 0x06 is sent alone inside its own select window. Chip select is then pulsed, and a new window opens with the write command 0x02.
- R5: When ADDR_BITS is 8 and the first word index of the burst is 128 or more, the write command becomes 0x0A (0x02 with 0x08 added).
- R6: After the write command, the byte address (twice the word index) is sent MSB first over ADDR_BITS bits, keeping its low ADDR_BITS bits.
- R7: Each word is sent as 16 bits, MSB first, with its bytes exchanged: the low byte goes out first, then the high byte.
- R8: After a word, if the next byte address is a multiple of PAGE_BYTES, or if the run is complete, chip select goes high. It stays high for exactly GAP_CYCLES clocks before a burst that is not the first reopens the device with a new status poll.
- R9: The serial clock only toggles while chip select is low. Data to the device changes only while the serial clock is low. It is 0 while status bits are clocked in and after the last bit of each field. Status bits are sampled at the end of the clock-high half period.
- R10: `wdata_ready_o` is high only while the block waits for a word of the current burst. While it is high, no serial clock edge occurs.
- R11: `done_o` pulses for exactly one clock after the settle time of the final burst. At that point chip select is high, and `done_o` is never high together with `err_o`.
- R12: During reset, chip select is high, and the serial clock, data to the device, `wdata_ready_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a run (ignored while a run is active) |
| offset_i | input | IW | First word index of the run |
| count_i | input | IW | Number of words in the run |
| wdata_i | input | 16 | Next data word |
| wdata_valid_i | input | 1 | Host offers `wdata_i` |
| wdata_ready_o | output | 1 | Block takes the word on this edge if valid |
| done_o | output | 1 | One-cycle pulse: the run has finished |
| err_o | output | 1 | One-cycle pulse: arguments refused or device stayed busy |
| cs_n_o | output | 1 | Active-low device select |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
An argument refusal is registered once, so the bench samples `err_o` at the falling edge right after the start edge and again one cycle later to see it drop. Completion time depends on how many polls the device model answers busy and on host stalls, so the bench waits for `done_o` or `err_o` within a bounded window. It then counts how many falling edges `done_o` was seen high, which must be exactly one. A behavioural device model decodes every select window edge by edge and logs the bytes. It also supplies the status bytes, and that log is compared with a byte stream built from the requirements. The link rules are checked at every falling clock edge: clock only while selected, data stable during clock-high, and no clock while waiting for a word. The settle time is checked by measuring the longest chip-select-high run inside a two-burst transfer.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_POLL_OP,
    ST_POLL_IN,
    ST_SB_HI,
    ST_SB_LO,
    ST_WREN,
    ST_WR_OP,
    ST_ADDR,
    ST_WREQ,
    ST_WORD,
    ST_GAP
  } seq_state_e;

  localparam logic [7:0] CMD_STATUS  = 8'h05;
  localparam logic [7:0] CMD_WR_EN   = 8'h06;
  localparam logic [7:0] CMD_WRITE   = 8'h02;
  localparam logic [7:0] CMD_HI_ADDR = 8'h08;

  function automatic logic [15:0] swap_bytes(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

endpackage

// File: rtl/spi_eep_tick.sv
module spi_eep_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/spi_eep_shifter.sv
module spi_eep_shifter #(
  parameter int MAXB = 16,
  localparam int NW = $clog2(MAXB + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            go_i,
  input  logic            rx_i,
  input  logic [NW-1:0]   nbits_i,
  input  logic [MAXB-1:0] data_i,
  input  logic            miso_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [7:0]      rx_byte_o,
  output logic            sclk_o,
  output logic            mosi_o
);
  typedef enum logic [1:0] {PH_SET, PH_HI, PH_LO} phase_e;

  phase_e          ph_q;
  logic [MAXB-1:0] sr_q;
  logic [NW-1:0]   left_q;
  logic            rx_q, busy_q, sk_q, done_q;
  logic [7:0]      rxb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_SET;
      sr_q   <= '0;
      left_q <= '0;
      rx_q   <= 1'b0;
      busy_q <= 1'b0;
      sk_q   <= 1'b0;
      done_q <= 1'b0;
      rxb_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          rx_q   <= rx_i;
          sr_q   <= data_i << (MAXB - int'(nbits_i));
          left_q <= nbits_i;
          ph_q   <= PH_SET;
          rxb_q  <= '0;
        end
      end else if (tick_i) begin
        case (ph_q)
          PH_SET: begin
            sk_q <= 1'b1;
            ph_q <= PH_HI;
          end
          PH_HI: begin
            sk_q <= 1'b0;
            ph_q <= PH_LO;
            if (rx_q) rxb_q <= {rxb_q[6:0], miso_i};
          end
          default: begin
            left_q <= left_q - 1'b1;
            if (left_q == NW'(1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              sr_q <= sr_q << 1;
              ph_q <= PH_SET;
            end
          end
        endcase
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_byte_o = rxb_q;
  assign sclk_o    = sk_q;
  assign mosi_o    = busy_q && !rx_q && sr_q[MAXB-1];

  // R9
  mosi_steady_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  // R9
  idle_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> !sclk_o);
endmodule

// File: rtl/spi_eep_argchk.sv
module spi_eep_argchk #(
  parameter int DEV_WORDS = 256,
  parameter int W = 9
) (
  input  logic [W-1:0] offset_i,
  input  logic [W-1:0] count_i,
  output logic         bad_o
);
  int off_v, cnt_v;
  always_comb begin
    off_v = int'(offset_i);
    cnt_v = int'(count_i);
    bad_o = (off_v >= DEV_WORDS) || (cnt_v == 0) || (cnt_v > DEV_WORDS - off_v);
  end
endmodule

// File: rtl/spi_eeprom_page_writer.sv
module spi_eeprom_page_writer
  import spi_eep_pkg::*;
#(
  parameter int CLK_DIV     = 8,
  parameter int OPCODE_BITS = 8,
  parameter int ADDR_BITS   = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int DEV_WORDS   = 256,
  parameter int RETRY_MAX   = 64,
  parameter int GAP_CYCLES  = 100000,
  localparam int IW = $clog2(DEV_WORDS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [IW-1:0] offset_i,
  input  logic [IW-1:0] count_i,
  input  logic [15:0]   wdata_i,
  input  logic          wdata_valid_i,
  output logic          wdata_ready_o,
  output logic          done_o,
  output logic          err_o,
  output logic          cs_n_o,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i
);
  localparam int SBW = 16;
  localparam int NW  = $clog2(SBW + 1);
  localparam int RW  = $clog2(RETRY_MAX + 1);
  localparam int GW  = $clog2(GAP_CYCLES + 1);

  seq_state_e    state_q, ret_q;
  logic [IW-1:0] idx_q, left_q;
  logic [RW-1:0] retry_q;
  logic [GW-1:0] gap_q;
  logic          armed_q, cs_q, done_q, err_q;
  logic [15:0]   word_q;

  logic          tick, arg_bad;
  logic          sh_req, sh_go, sh_rx, sh_busy, sh_done;
  logic [NW-1:0] sh_nbits;
  logic [15:0]   sh_data;
  logic [7:0]    sh_rxb;
  logic [IW:0]   byte_addr, next_byte;
  logic [IW-1:0] next_idx;
  logic          page_end, hi_half;
  logic [7:0]    wr_cmd;

  spi_eep_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  spi_eep_argchk #(.DEV_WORDS(DEV_WORDS), .W(IW)) u_args (
    .offset_i(offset_i), .count_i(count_i), .bad_o(arg_bad)
  );

  spi_eep_shifter #(.MAXB(SBW)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .go_i(sh_go), .rx_i(sh_rx),
    .nbits_i(sh_nbits), .data_i(sh_data), .miso_i(miso_i),
    .busy_o(sh_busy), .done_o(sh_done), .rx_byte_o(sh_rxb),
    .sclk_o(sclk_o), .mosi_o(mosi_o)
  );

  assign byte_addr = {idx_q, 1'b0};
  assign next_idx  = idx_q + 1'b1;
  assign next_byte = {next_idx, 1'b0};
  assign page_end  = (int'(next_byte) % PAGE_BYTES) == 0;
  assign hi_half   = (ADDR_BITS == 8) && (int'(idx_q) >= 128);
  assign wr_cmd    = hi_half ? (CMD_WRITE | CMD_HI_ADDR) : CMD_WRITE;

  // field selection for the shared shifter
  always_comb begin
    sh_req   = 1'b1;
    sh_rx    = 1'b0;
    sh_nbits = NW'(OPCODE_BITS);
    sh_data  = '0;
    case (state_q)
      ST_POLL_OP: sh_data = {8'h00, CMD_STATUS};
      ST_POLL_IN: begin sh_rx = 1'b1; sh_nbits = NW'(8); end
      ST_WREN:    sh_data = {8'h00, CMD_WR_EN};
      ST_WR_OP:   sh_data = {8'h00, wr_cmd};
      ST_ADDR:    begin sh_nbits = NW'(ADDR_BITS); sh_data = 16'(byte_addr); end
      ST_WORD:    begin sh_nbits = NW'(16); sh_data = swap_bytes(word_q); end
      default:    sh_req = 1'b0;
    endcase
    sh_go = sh_req && !armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      idx_q   <= '0;
      left_q  <= '0;
      retry_q <= '0;
      gap_q   <= '0;
      armed_q <= 1'b0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (sh_done)    armed_q <= 1'b0;
      else if (sh_go) armed_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (arg_bad) err_q <= 1'b1;
          else begin
            idx_q   <= offset_i;
            left_q  <= count_i;
            retry_q <= '0;
            cs_q    <= 1'b0;
            state_q <= ST_SEL;
          end
        end
        ST_SEL: if (tick) state_q <= ST_POLL_OP;
        ST_POLL_OP: if (sh_done) state_q <= ST_POLL_IN;
        ST_POLL_IN: if (sh_done) begin
          cs_q <= 1'b1;
          if (!sh_rxb[0]) begin
            ret_q   <= ST_WREN;
            state_q <= ST_SB_HI;
          end else if (retry_q == RW'(RETRY_MAX - 1)) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            retry_q <= retry_q + 1'b1;
            ret_q   <= ST_POLL_OP;
            state_q <= ST_SB_HI;
          end
        end
        ST_SB_HI: if (tick) begin
          cs_q    <= 1'b0;
          state_q <= ST_SB_LO;
        end
        ST_SB_LO: if (tick) state_q <= ret_q;
        ST_WREN: if (sh_done) begin
          cs_q    <= 1'b1;
          ret_q   <= ST_WR_OP;
          state_q <= ST_SB_HI;
        end
        ST_WR_OP: if (sh_done) state_q <= ST_ADDR;
        ST_ADDR:  if (sh_done) state_q <= ST_WREQ;
        ST_WREQ: if (wdata_valid_i) begin
          word_q  <= wdata_i;
          state_q <= ST_WORD;
        end
        ST_WORD: if (sh_done) begin
          idx_q  <= next_idx;
          left_q <= left_q - 1'b1;
          if (left_q == IW'(1) || page_end) begin
            cs_q    <= 1'b1;
            gap_q   <= '0;
            state_q <= ST_GAP;
          end else begin
            state_q <= ST_WREQ;
          end
        end
        ST_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GW'(GAP_CYCLES - 1)) begin
            if (left_q == '0) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              retry_q <= '0;
              cs_q    <= 1'b0;
              state_q <= ST_SEL;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wdata_ready_o = (state_q == ST_WREQ);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign cs_n_o        = cs_q;

  // R1
  bad_args_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == ST_IDLE && arg_bad) |=> (err_o && cs_n_o));

  // R9
  clock_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R10
  stall_freezes_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_ready_o |-> (!sclk_o && !sh_busy));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R3
  end_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> cs_n_o);
endmodule

// File: tb/spi_eeprom_page_writer_tb.sv
module spi_eeprom_page_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int RET  = 4;
  localparam int GAP  = 40;
  localparam int PAGE = 16;
  localparam int IW   = 9;
  localparam logic [7:0] ST_BUSY  = 8'h03;
  localparam logic [7:0] ST_READY = 8'hF0;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IW-1:0] off = '0, cnt = '0;
  logic [15:0] wdata = '0;
  logic wvalid = 1'b0, miso = 1'b0;
  logic wready, done, err, cs_n, sclk, mosi;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_page_writer #(
    .CLK_DIV(DIV), .PAGE_BYTES(PAGE), .RETRY_MAX(RET), .GAP_CYCLES(GAP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .offset_i(off), .count_i(cnt),
    .wdata_i(wdata), .wdata_valid_i(wvalid), .wdata_ready_o(wready),
    .done_o(done), .err_o(err), .cs_n_o(cs_n), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int pat(input int i);
    return ((i * 16'h1357) ^ 16'hC3A5) & 16'hFFFF;
  endfunction

  // behavioural device: decodes select windows into a byte log
  int log_q[$];
  int exp_q[$];
  int busy_left = 0;
  logic sk_p = 1'b0, cs_p = 1'b1;
  int fbits = 0;
  logic [7:0] sbyte = '0, opc = '0, stat = '0;
  bit fr_busy = 0;

  always @(posedge clk) begin
    if (cs_p && !cs_n) begin
      fbits = 0; opc = '0; fr_busy = (busy_left > 0);
      stat = fr_busy ? ST_BUSY : ST_READY;
    end
    if (!cs_p && cs_n) begin
      if (opc == 8'h05 && fr_busy && busy_left > 0) busy_left--;
      log_q.push_back(-1);
      miso <= 1'b0;
    end
    if (!cs_n && !sk_p && sclk) begin
      sbyte = {sbyte[6:0], mosi};
      fbits++;
      if (fbits % 8 == 0) begin
        log_q.push_back(int'(sbyte));
        if (fbits == 8) opc = sbyte;
      end
    end
    if (!cs_n && sk_p && !sclk) begin
      if (opc == 8'h05 && fbits >= 8 && fbits < 16) miso <= stat[15 - fbits];
    end
    sk_p = sclk;
    cs_p = cs_n;
  end

  // host word source with optional stall before each word
  int dq[$];
  int stall_n = 0, stall_c = 0;
  always @(posedge clk) begin
    if (wvalid && wready) begin
      void'(dq.pop_front());
      stall_c = stall_n;
    end
  end
  always @(negedge clk) begin
    if (stall_c > 0) begin
      stall_c--;
      wvalid <= 1'b0;
    end else if (dq.size() > 0) begin
      wvalid <= 1'b1;
      wdata  <= dq[0][15:0];
    end else begin
      wvalid <= 1'b0;
    end
  end

  // link rules checked on every clock
  logic sk_n = 1'b0, di_n = 1'b0;
  int run = 0, maxrun = 0, done_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(cs_n && sclk), "R9", "clock while deselected", sclk, 0);
      if (sclk && sk_n) chk(mosi == di_n, "R9", "data moved while clock high", mosi, di_n);
      chk(!(wready && sclk), "R10", "clock while waiting word", sclk, 0);
      chk(!(done && err), "R11", "done with err", done, 0);
      if (done) done_cnt++;
      if (cs_n) run++;
      else begin
        if (run > maxrun) maxrun = run;
        run = 0;
      end
      sk_n = sclk;
      di_n = mosi;
    end
  end

  task automatic go(input int o, input int c, output bit e);
    @(negedge clk);
    off = IW'(o); cnt = IW'(c); start = 1'b1;
    @(negedge clk);
    e = err;
    start = 1'b0;
  endtask

  task automatic wait_end(output bit gd, output bit ge);
    gd = 0; ge = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin gd = 1; break; end
      if (err)  begin ge = 1; break; end
    end
  endtask

  function automatic void build_exp(input int o, input int c, input int busy_n);
    int idx, k, polls, w;
    bit first, stop;
    exp_q.delete();
    idx = o; k = 0; first = 1;
    while (k < c) begin
      polls = first ? busy_n + 1 : 1;
      first = 0;
      for (int p = 0; p < polls; p++) begin
        exp_q.push_back(8'h05); exp_q.push_back(0); exp_q.push_back(-1);
      end
      exp_q.push_back(8'h06); exp_q.push_back(-1);
      exp_q.push_back(idx >= 128 ? 8'h0A : 8'h02);   // R5
      exp_q.push_back((2 * idx) & 255);              // R6
      stop = 0;
      while (!stop) begin
        w = pat(idx);
        exp_q.push_back(w & 255);                    // R7 low byte first
        exp_q.push_back((w >> 8) & 255);
        idx++; k++;
        if (k >= c || ((2 * idx) % PAGE) == 0) stop = 1;
      end
      exp_q.push_back(-1);
    end
  endfunction

  task automatic compare(input string req);
    int bad_at;
    bad_at = -1;
    chk(log_q.size() == exp_q.size(), req, "byte stream length", log_q.size(), exp_q.size());
    for (int i = 0; i < log_q.size() && i < exp_q.size(); i++)
      if (bad_at < 0 && log_q[i] != exp_q[i]) bad_at = i;
    if (bad_at >= 0) chk(0, req, "byte stream content", log_q[bad_at], exp_q[bad_at]);
    else chk(1, req, "byte stream content", 0, 0);
  endtask

  task automatic run_write(input int o, input int c, input int busy_n,
                           input int stall, input string req);
    bit e, gd, ge;
    busy_left = busy_n;
    log_q.delete();
    dq.delete();
    for (int i = 0; i < c; i++) dq.push_back(pat(o + i));
    stall_n = stall; stall_c = stall;
    maxrun = 0; run = 0; done_cnt = 0;
    go(o, c, e);
    chk(!e, "R1", "valid start refused", e, 0);
    wait_end(gd, ge);
    chk(gd && !ge, "R11", "run completes with done", gd, 1);
    chk(cs_n == 1'b1, "R11", "deselected at done", cs_n, 1);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R11", "done width in cycles", done_cnt, 1);
    build_exp(o, c, busy_n);
    compare(req);
  endtask

  task automatic bad_start(input int o, input int c);
    bit e;
    log_q.delete();
    go(o, c, e);
    chk(e == 1'b1, "R1", "refusal pulse one cycle after start", e, 1);
    @(negedge clk);
    chk(err == 1'b0, "R1", "refusal pulse width", err, 0);
    repeat (20) @(negedge clk);
    chk(log_q.size() == 0 && cs_n, "R1", "link idle after refusal", log_q.size(), 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 300000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit e, gd, ge;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(cs_n == 1'b1, "R12", "select in reset", cs_n, 1);
    chk(!sclk && !mosi, "R12", "clock/data in reset", {sclk, mosi}, 0);
    chk(!wready && !done && !err, "R12", "status in reset", {wready, done, err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4 R6 R7: single burst in one page
    run_write(3, 4, 0, 0, "R7");
    // R8: crosses a page boundary, two bursts
    run_write(6, 5, 0, 0, "R8");
    chk(maxrun == GAP, "R8", "select-high settle between bursts", maxrun, GAP);
    // R5: upper half of the array
    run_write(130, 2, 0, 0, "R5");
    run_write(255, 1, 0, 0, "R5");
    // R1: run ending exactly at the last word is accepted
    run_write(250, 6, 0, 0, "R1");
    // R2: two busy polls, non-zero upper status bits ignored
    run_write(20, 1, 2, 0, "R2");
    // R10: host stalls before each word
    run_write(40, 3, 0, 25, "R10");
    // R1 refusals
    bad_start(256, 1);
    bad_start(10, 0);
    bad_start(250, 7);
    // R3: device never ready
    busy_left = 100000;
    log_q.delete();
    dq.delete();
    go(60, 2, e);
    wait_end(gd, ge);
    chk(ge && !gd, "R3", "error after poll limit", ge, 1);
    chk(cs_n == 1'b1, "R3", "deselected on error", cs_n, 1);
    exp_q.delete();
    for (int i = 0; i < RET; i++) begin
      exp_q.push_back(8'h05); exp_q.push_back(0); exp_q.push_back(-1);
    end
    repeat (3) @(negedge clk);
    compare("R3");
    busy_left = 0;
    // R3: block accepts a new run afterwards
    run_write(0, 1, 0, 0, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule